// File: doc/BRIEF.md
# Filtered Diagnostic Flag Latch

This block gathers raw fault indications for four power channels and turns them into latched diagnosis. Each channel reports four conditions: short to ground, open load, over-load and over-temperature. Short to ground, open load and over-load must be present without a break for a programmable number of clock samples before they count as real. Over-temperature is taken on its first sample. Once a condition counts as real, it is latched. It stays latched until the serial interface sends a clear pulse at the end of a valid transfer. Reading the status does not clear it.

The latched state of each channel is reduced to a 2-bit status code. Over-load and over-temperature share a single protection code. The four codes are packed into an 8-bit diagnosis word, whose all-ones value means that every channel is healthy. The block also gives a 1-bit health summary per channel and an active-low fault line, which goes low as soon as any channel holds a latched fault. The filter length comes in as a port value, counted in system clock cycles. At a 20 MHz clock, about 2200 cycles gives the nominal 110 µs.

Top module: `diag_latch_top`

## Requirements
- R1: After reset the diagnosis word is 8'hFF, the summary is 4'b1111 and fault_n is 1.
- R2: A short to ground, open load or over-load indication latches at the clock edge that samples it high for the filt_len-th consecutive time. A single low sample restarts the count. A filt_len of 0 or 1 latches on the first high sample.
- R3: An over-temperature indication latches at the first clock edge that samples it high.
- R4: The channel code is 2'b00 for short to ground, 2'b01 for open load, 2'b10 for over-load or over-temperature, and 2'b11 for no fault.
- R5: Channel i (0 to 3) places its code in diag_word bits [2i+1:2i], so channel 0 is in bits 1:0 and channel 3 is in bits 7:6.
- R6: A latched flag stays set after its raw indication goes away, for as long as no clear pulse arrives.
- R7: A clear pulse sampled at a clock edge clears every latched flag and every filter count at that edge. The clear wins over a flag that would be set at the same edge.
- R8: If a filtered condition is still present after a clear, it latches again only after a new run of filt_len samples. An over-temperature indication that is still present latches again at the first edge after the clear pulse.
- R9: When several flags are latched on one channel, the code shows short to ground first, then open load, then protection.
- R10: chan_ok[i] is 1 when channel i has no latched flag and 0 otherwise. fault_n is 0 whenever any channel has a latched flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| filt_len | input | 16 | Filter length in clock cycles |
| sgnd_raw | input | 4 | Raw short-to-ground indication per channel |
| open_raw | input | 4 | Raw open-load indication per channel |
| ovl_raw | input | 4 | Raw over-load indication per channel |
| otmp_raw | input | 4 | Raw over-temperature indication per channel |
| clr_pulse | input | 1 | One-cycle clear from the serial interface after a valid transfer |
| diag_word | output | 8 | Packed 2-bit status codes for the four channels |
| chan_ok | output | 4 | Per-channel health summary, 1 means no fault |
| fault_n | output | 1 | Active-low global fault line |

## Verification
The assertions assume that every raw indication and clr_pulse is synchronous to clk and is already stable when each edge samples it. They also assume that filt_len is held steady while a filter run is in progress, so a latch time can be tied to a count of samples. The bench changes inputs only on falling edges and reads outputs there too. It changes filt_len only while all raw inputs are low and the flags have been cleared. It drives every input to zero from time zero, so the history checks never see unknown values.

// File: rtl/diag_pkg.sv
package diag_pkg;

  typedef enum logic [1:0] {
    CODE_SGND = 2'b00,
    CODE_OPEN = 2'b01,
    CODE_PROT = 2'b10,
    CODE_OK   = 2'b11
  } diag_code_e;

  // indices of the filtered conditions inside a channel
  localparam int COND_SGND = 0;
  localparam int COND_OPEN = 1;
  localparam int COND_OVL  = 2;
  localparam int N_FILT    = 3;

  // priority: short to ground, then open load, then protection
  function automatic diag_code_e encode_code(input logic sg, input logic ol,
                                             input logic pr);
    if (sg)      return CODE_SGND;
    else if (ol) return CODE_OPEN;
    else if (pr) return CODE_PROT;
    else         return CODE_OK;
  endfunction

endpackage

// File: rtl/fault_filter.sv
module fault_filter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic             clr,
  input  logic [CNT_W-1:0] len,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;

  // true when the current sample completes a run of len samples
  function automatic logic run_done(input logic [CNT_W-1:0] cnt,
                                    input logic [CNT_W-1:0] lim);
    logic [CNT_W:0] nxt;
    nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    return nxt >= {1'b0, lim};
  endfunction

  assign hit = raw && run_done(cnt_q, len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr || !raw)     cnt_q <= '0;
    else if (!hit)            cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end

endmodule

// File: rtl/chan_diag.sv
module chan_diag
  import diag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] filt_len,
  input  logic             sgnd_raw,
  input  logic             open_raw,
  input  logic             ovl_raw,
  input  logic             otmp_raw,
  input  logic             clr,
  output diag_code_e       code,
  output logic             ok,
  output logic             flg_sg,
  output logic             flg_ol,
  output logic             flg_pr
);

  logic [N_FILT-1:0] raw_f;
  logic [N_FILT-1:0] hit_f;
  logic [N_FILT-1:0] flag_f;
  logic              flag_ot;

  always_comb begin
    raw_f            = '0;
    raw_f[COND_SGND] = sgnd_raw;
    raw_f[COND_OPEN] = open_raw;
    raw_f[COND_OVL]  = ovl_raw;
  end

  for (genvar k = 0; k < N_FILT; k++) begin : g_filt
    fault_filter #(.CNT_W(CNT_W)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_f[k]),
      .clr  (clr),
      .len  (filt_len),
      .hit  (hit_f[k])
    );
    sticky_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (hit_f[k]),
      .clr  (clr),
      .flag (flag_f[k])
    );
  end

  // over-temperature skips the time filter
  sticky_flag u_otmp (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (otmp_raw),
    .clr  (clr),
    .flag (flag_ot)
  );

  assign flg_sg = flag_f[COND_SGND];
  assign flg_ol = flag_f[COND_OPEN];
  assign flg_pr = flag_f[COND_OVL] | flag_ot;
  assign code   = encode_code(flg_sg, flg_ol, flg_pr);
  assign ok     = ~(|flag_f | flag_ot);

endmodule

// File: rtl/diag_latch_top.sv
module diag_latch_top
  import diag_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int CNT_W = 16,
  localparam int WORD_W = 2 * N_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  filt_len,
  input  logic [N_CH-1:0]   sgnd_raw,
  input  logic [N_CH-1:0]   open_raw,
  input  logic [N_CH-1:0]   ovl_raw,
  input  logic [N_CH-1:0]   otmp_raw,
  input  logic              clr_pulse,
  output logic [WORD_W-1:0] diag_word,
  output logic [N_CH-1:0]   chan_ok,
  output logic              fault_n
);

  // per-channel latched flags, named for the checker
  logic [N_CH-1:0] flag_sg;
  logic [N_CH-1:0] flag_ol;
  logic [N_CH-1:0] flag_pr;
  diag_code_e      code_ch [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    chan_diag #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .filt_len(filt_len),
      .sgnd_raw(sgnd_raw[i]),
      .open_raw(open_raw[i]),
      .ovl_raw (ovl_raw[i]),
      .otmp_raw(otmp_raw[i]),
      .clr     (clr_pulse),
      .code    (code_ch[i]),
      .ok      (chan_ok[i]),
      .flg_sg  (flag_sg[i]),
      .flg_ol  (flag_ol[i]),
      .flg_pr  (flag_pr[i])
    );
    assign diag_word[2*i +: 2] = code_ch[i];
  end

  assign fault_n = &chan_ok;

endmodule

// File: rtl/diag_latch_chk.sv
module diag_latch_chk #(
  parameter int N_CH  = 4,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  filt_len,
  input logic [N_CH-1:0]   sgnd_raw,
  input logic [N_CH-1:0]   otmp_raw,
  input logic              clr_pulse,
  input logic [2*N_CH-1:0] diag_word,
  input logic [N_CH-1:0]   chan_ok,
  input logic [N_CH-1:0]   flag_sg
);

  // R7
  clear_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (&diag_word));

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R3
    otmp_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (otmp_raw[i] && !clr_pulse) |=> !chan_ok[i]);

    // R2
    filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sgnd_raw[i] && !$past(sgnd_raw[i]) && filt_len > 1 && !flag_sg[i])
      |=> !flag_sg[i]);

    // R6
    sticky_sg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_sg[i] && !clr_pulse) |=> flag_sg[i]);

    // R9
    sg_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_sg[i] |-> (diag_word[2*i +: 2] == 2'b00));

    // R10
    summary_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_ok[i] == (diag_word[2*i +: 2] == 2'b11));
  end

endmodule

bind diag_latch_top diag_latch_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .filt_len (filt_len),
  .sgnd_raw (sgnd_raw),
  .otmp_raw (otmp_raw),
  .clr_pulse(clr_pulse),
  .diag_word(diag_word),
  .chan_ok  (chan_ok),
  .flag_sg  (flag_sg)
);

// File: tb/diag_latch_top_tb.sv
module diag_latch_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] filt_len = 16'(FL);
  logic [3:0]  sgnd_raw = '0;
  logic [3:0]  open_raw = '0;
  logic [3:0]  ovl_raw = '0;
  logic [3:0]  otmp_raw = '0;
  logic        clr_pulse = 1'b0;
  logic [7:0]  diag_word;
  logic [3:0]  chan_ok;
  logic        fault_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  diag_latch_top dut_i (
    .clk(clk), .rst_n(rst_n), .filt_len(filt_len),
    .sgnd_raw(sgnd_raw), .open_raw(open_raw), .ovl_raw(ovl_raw),
    .otmp_raw(otmp_raw), .clr_pulse(clr_pulse),
    .diag_word(diag_word), .chan_ok(chan_ok), .fault_n(fault_n)
  );

  // expected word: all channels healthy except channel ch carrying code c
  function automatic logic [7:0] one_code(input int ch, input logic [1:0] c);
    logic [7:0] w;
    w = 8'hFF;
    w[2*ch +: 2] = c;
    return w;
  endfunction

  task automatic chk(input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    sgnd_raw = '0; open_raw = '0; ovl_raw = '0; otmp_raw = '0;
    clr_pulse = 1'b1;
    tick(1);
    clr_pulse = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 word", diag_word, 8'hFF);
    chk("R1 summary", {4'h0, chan_ok}, 8'h0F);
    chk("R1 fault_n", {7'h0, fault_n}, 8'h01);
  endtask

  task automatic t_filter_sticky();
    sgnd_raw[2] = 1'b1;
    tick(FL - 1);
    chk("R2 before run ends", diag_word, 8'hFF);
    tick(1);
    chk("R5 ch2 short", diag_word, one_code(2, 2'b00));
    chk("R10 summary", {4'h0, chan_ok}, 8'h0B);
    chk("R10 fault_n", {7'h0, fault_n}, 8'h00);
    sgnd_raw[2] = 1'b0;
    tick(3);
    chk("R6 held", diag_word, one_code(2, 2'b00));
    clear_all();
    chk("R7 cleared", diag_word, 8'hFF);
  endtask

  task automatic t_gap_and_relatch();
    open_raw[0] = 1'b1;
    tick(3);
    open_raw[0] = 1'b0;
    tick(1);
    open_raw[0] = 1'b1;
    tick(FL - 1);
    chk("R2 gap restarts", diag_word, 8'hFF);
    tick(1);
    chk("R4 open code", diag_word, one_code(0, 2'b01));
    clr_pulse = 1'b1;
    tick(1);
    clr_pulse = 1'b0;
    chk("R7 clear with raw", diag_word, 8'hFF);
    tick(FL - 1);
    chk("R8 new run needed", diag_word, 8'hFF);
    tick(1);
    chk("R8 relatched", diag_word, one_code(0, 2'b01));
    clear_all();
  endtask

  task automatic t_overtemp();
    otmp_raw[3] = 1'b1;
    tick(1);
    chk("R3 immediate", diag_word, one_code(3, 2'b10));
    clr_pulse = 1'b1;
    tick(1);
    chk("R7 clear beats set", diag_word, 8'hFF);
    clr_pulse = 1'b0;
    tick(1);
    chk("R8 otmp relatch", diag_word, one_code(3, 2'b10));
    clear_all();
    chk("R7 after otmp", diag_word, 8'hFF);
  endtask

  task automatic t_overload();
    ovl_raw[1] = 1'b1;
    tick(FL - 1);
    chk("R2 ovl filtered", diag_word, 8'hFF);
    tick(1);
    chk("R4 prot code", diag_word, one_code(1, 2'b10));
    clear_all();
  endtask

  task automatic t_priority();
    sgnd_raw[1] = 1'b1; open_raw[1] = 1'b1; ovl_raw[1] = 1'b1;
    tick(FL);
    chk("R9 short first", diag_word, one_code(1, 2'b00));
    clear_all();
    open_raw[1] = 1'b1; ovl_raw[1] = 1'b1;
    tick(FL);
    chk("R9 open over prot", diag_word, one_code(1, 2'b01));
    clear_all();
    open_raw[1] = 1'b1; otmp_raw[1] = 1'b1;
    tick(1);
    chk("R9 prot alone", diag_word, one_code(1, 2'b10));
    tick(FL - 1);
    chk("R9 open takes over", diag_word, one_code(1, 2'b01));
    clear_all();
  endtask

  task automatic t_short_filter();
    filt_len = 16'd1;
    sgnd_raw[0] = 1'b1;
    tick(1);
    chk("R2 len one", diag_word, one_code(0, 2'b00));
    clear_all();
    filt_len = 16'd0;
    open_raw[0] = 1'b1;
    tick(1);
    chk("R2 len zero", diag_word, one_code(0, 2'b01));
    clear_all();
    filt_len = 16'(FL);
  endtask

  task automatic t_all_channels();
    otmp_raw = 4'hF;
    tick(1);
    chk("R5 all prot", diag_word, 8'hAA);
    chk("R10 all bad", {4'h0, chan_ok}, 8'h00);
    clear_all();
    chk("R10 back ok", {7'h0, fault_n}, 8'h01);
  endtask

  task automatic t_clear_race();
    sgnd_raw[3] = 1'b1;
    tick(FL - 1);
    clr_pulse = 1'b1;
    tick(1);
    clr_pulse = 1'b0;
    chk("R7 race", diag_word, 8'hFF);
    tick(FL - 1);
    chk("R8 race no latch", diag_word, 8'hFF);
    tick(1);
    chk("R8 race latch", diag_word, one_code(3, 2'b00));
    clear_all();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_filter_sticky();
    t_gap_and_relatch();
    t_overtemp();
    t_overload();
    t_priority();
    t_short_filter();
    t_all_channels();
    t_clear_race();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule